// File: doc/BRIEF.md
# Four-Port Register Calculator with Branch Skip

The block is a calculator shared by four independent command ports. Operands never travel with a command. Each command names source and destination slots in a common bank of 16 registers, each 32 bits wide. The commands are add, subtract, shift left, shift right, store, fetch, branch-if-zero and branch-if-equal. Store copies the port's data word into a register. Fetch returns a register on the response data bus.

Every command that is presented produces one response in the following cycle. The response echoes the command's tag and carries a 2-bit code: 01 for success, 10 for error (overflow, underflow or an unknown opcode) and 11 for skipped. A branch that is taken cancels the next command issued on its own port. That cancelled command changes no register and returns no data. The other ports are not affected.

All four ports can execute in the same cycle. They all read the register contents as they stood before that cycle's edge. Their writes land at that edge, and when two ports target the same register, the lower-numbered port's write is the one kept.

Top module: `calc_core`

## Requirements
- R1: After reset, no response is valid and every one of the 16 registers reads as zero.
- R2: Add (opcode 1) writes ra+rb into rd and returns the sum with code 01. If the unsigned sum exceeds 32 bits, it returns code 10 with data 0 and rd keeps its value. A sum of exactly FFFFFFFF is a success.
- R3: Subtract (opcode 2) writes ra-rb into rd with code 01. If rb is greater than ra, it returns code 10 with data 0 and nothing is written. Equal operands give 0 with code 01.
- R4: Shift left (opcode 5) and shift right (opcode 6) shift ra by the low 5 bits of rb, filling with zeros. The result is written into rd and returned with code 01.
- R5: Store (opcode 9) writes the port's data word into rd and returns code 01 with data 0.
- R6: Fetch (opcode 10) returns register ra with code 01 and writes nothing.
- R7: Branch-if-zero (opcode 12) is taken when ra is zero. Branch-if-equal (opcode 13) is taken when ra equals rb. Both return code 01 with data 1 when taken and 0 when not taken, and write nothing.
- R8: After a taken branch, the next non-idle command on the same port is skipped: code 11, data 0, no register write. Idle cycles in between do not clear the pending skip, and other ports are unaffected.
- R9: A branch that is skipped evaluates as false, so the command after it executes normally.
- R10: Any other non-zero opcode returns code 10 with data 0 and writes nothing.
- R11: When several ports write the same register in one cycle, the lowest-numbered port's value is kept.
- R12: Opcode 0 is idle and gives no response. Any other opcode gives exactly one response in the following cycle, with the command's tag echoed.
- R13: Commands in one cycle read register values from before that cycle. A command in the next cycle sees the writes.
- R14: No two ports present non-idle commands with the same tag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 16 | Opcode, 4 bits per port, port 0 in the low bits |
| cmd_tag | input | 8 | Tag, 2 bits per port |
| cmd_ra | input | 16 | First source register index, 4 bits per port |
| cmd_rb | input | 16 | Second source register index, 4 bits per port |
| cmd_rd | input | 16 | Destination register index, 4 bits per port |
| cmd_data | input | 128 | Store data, 32 bits per port |
| rsp_vld | output | 4 | Response valid, one bit per port |
| rsp_code | output | 8 | Response code, 2 bits per port |
| rsp_tag | output | 8 | Echoed tag, 2 bits per port |
| rsp_data | output | 128 | Response data, 32 bits per port |

## Verification
Two pairs of events can fall into the same cycle. The first pair is writes by several ports to one register; the second is a pending skip on a port meeting a fresh branch on that same port. Directed steps set up both cases on purpose. All four ports store different words into one register, and a fetch in the next cycle must return port 0's word. Separately, a taken branch is followed directly by another branch and then by a store, and the expected responses are 11 for the skipped branch and a normal write for the store. A long random run then mixes all opcodes on every port, with a small pool of values so that branches are often taken. Each port's response is compared every cycle against a behavioural model that applies writes in port priority order.

// File: rtl/calc_pkg.sv
package calc_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_SHL   = 4'd5,
    OP_SHR   = 4'd6,
    OP_STORE = 4'd9,
    OP_FETCH = 4'd10,
    OP_BRZ   = 4'd12,
    OP_BREQ  = 4'd13
  } op_e;

  typedef enum logic [1:0] {
    RSP_NONE = 2'b00,
    RSP_OK   = 2'b01,
    RSP_ERR  = 2'b10,
    RSP_SKIP = 2'b11
  } rsp_e;
endpackage

// File: rtl/calc_regfile.sv
module calc_regfile #(
  parameter int NP = 4,
  parameter int DW = 32,
  parameter int NR = 16,
  localparam int AW = $clog2(NR)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0][AW-1:0]  rd_addr_a,
  input  logic [NP-1:0][AW-1:0]  rd_addr_b,
  output logic [NP-1:0][DW-1:0]  rd_val_a,
  output logic [NP-1:0][DW-1:0]  rd_val_b,
  input  logic [NP-1:0]          wr_en,
  input  logic [NP-1:0][AW-1:0]  wr_addr,
  input  logic [NP-1:0][DW-1:0]  wr_data
);
  logic [NR-1:0][DW-1:0] mem;

  // Writes are applied from the highest port down, so the lowest port's
  // nonblocking assignment is the last one and wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else begin
      for (int p = NP - 1; p >= 0; p--) begin
        if (wr_en[p]) mem[wr_addr[p]] <= wr_data[p];
      end
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_rd
    assign rd_val_a[p] = mem[rd_addr_a[p]];
    assign rd_val_b[p] = mem[rd_addr_b[p]];
  end

  // R11: port 0 always owns its destination after the edge
  p_port0_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] |=> mem[$past(wr_addr[0])] == $past(wr_data[0]));
endmodule

// File: rtl/calc_port.sv
module calc_port
  import calc_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int TW = 2,
  localparam int SHW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op,
  input  logic [TW-1:0]  tag,
  input  logic [AW-1:0]  rd,
  input  logic [DW-1:0]  data,
  input  logic [DW-1:0]  va,
  input  logic [DW-1:0]  vb,
  output logic           wr_en,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic           rsp_vld,
  output logic [1:0]     rsp_code,
  output logic [TW-1:0]  rsp_tag,
  output logic [DW-1:0]  rsp_data
);
  function automatic logic [DW:0] f_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [DW:0] f_sub(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {1'b0, a} - {1'b0, b};
  endfunction

  logic          skip_q;
  logic          ev_vld, ev_skip, ev_exec, ev_taken, ev_ovf, ev_unf;
  logic          ok, wr;
  logic [DW:0]   sum, dif;
  logic [DW-1:0] res, out;

  assign ev_vld  = (op != OP_NOP);
  assign ev_skip = ev_vld & skip_q;
  assign ev_exec = ev_vld & ~skip_q;
  assign sum     = f_add(va, vb);
  assign dif     = f_sub(va, vb);
  assign ev_ovf  = ev_exec & (op == OP_ADD) & sum[DW];
  assign ev_unf  = ev_exec & (op == OP_SUB) & dif[DW];

  always_comb begin
    ok = 1'b1; wr = 1'b0; res = '0; out = '0; ev_taken = 1'b0;
    case (op)
      OP_ADD:   begin ok = ~sum[DW]; res = sum[DW-1:0]; wr = ok; out = ok ? res : '0; end
      OP_SUB:   begin ok = ~dif[DW]; res = dif[DW-1:0]; wr = ok; out = ok ? res : '0; end
      OP_SHL:   begin res = va << vb[SHW-1:0]; wr = 1'b1; out = res; end
      OP_SHR:   begin res = va >> vb[SHW-1:0]; wr = 1'b1; out = res; end
      OP_STORE: begin res = data; wr = 1'b1; end
      OP_FETCH: out = va;
      OP_BRZ:   begin ev_taken = (va == '0); out = DW'(ev_taken); end
      OP_BREQ:  begin ev_taken = (va == vb); out = DW'(ev_taken); end
      default:  ok = 1'b0;
    endcase
  end

  assign wr_en   = ev_exec & wr;
  assign wr_addr = rd;
  assign wr_data = res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q   <= 1'b0;
      rsp_vld  <= 1'b0;
      rsp_code <= RSP_NONE;
      rsp_tag  <= '0;
      rsp_data <= '0;
    end else begin
      if (ev_vld) skip_q <= ev_exec & ev_taken;
      rsp_vld  <= ev_vld;
      rsp_tag  <= tag;
      rsp_code <= !ev_vld ? RSP_NONE : ev_skip ? RSP_SKIP : ok ? RSP_OK : RSP_ERR;
      rsp_data <= ev_exec ? out : '0;
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> rsp_code == RSP_ERR && rsp_data == '0);
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unf |=> rsp_code == RSP_ERR && rsp_data == '0);
  p_skip_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip |=> rsp_code == RSP_SKIP && rsp_data == '0);
  p_skip_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip |=> !skip_q);
  p_resp_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vld |=> rsp_vld && rsp_tag == $past(tag));
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_vld |=> !rsp_vld && rsp_code == RSP_NONE);
endmodule

// File: rtl/calc_core.sv
module calc_core
  import calc_pkg::*;
#(
  parameter int NP = 4,
  parameter int DW = 32,
  parameter int NR = 16,
  parameter int TW = 2,
  localparam int AW = $clog2(NR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP*OPW-1:0] cmd_op,
  input  logic [NP*TW-1:0] cmd_tag,
  input  logic [NP*AW-1:0] cmd_ra,
  input  logic [NP*AW-1:0] cmd_rb,
  input  logic [NP*AW-1:0] cmd_rd,
  input  logic [NP*DW-1:0] cmd_data,
  output logic [NP-1:0]    rsp_vld,
  output logic [NP*2-1:0]  rsp_code,
  output logic [NP*TW-1:0] rsp_tag,
  output logic [NP*DW-1:0] rsp_data
);
  logic [NP-1:0][AW-1:0] ra_w, rb_w, wa_w;
  logic [NP-1:0][DW-1:0] va_w, vb_w, wd_w;
  logic [NP-1:0]         we_w;

  calc_regfile #(.NP(NP), .DW(DW), .NR(NR)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(ra_w), .rd_addr_b(rb_w),
    .rd_val_a(va_w), .rd_val_b(vb_w),
    .wr_en(we_w), .wr_addr(wa_w), .wr_data(wd_w)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign ra_w[p] = cmd_ra[p*AW +: AW];
    assign rb_w[p] = cmd_rb[p*AW +: AW];

    calc_port #(.DW(DW), .AW(AW), .TW(TW)) u_port (
      .clk(clk), .rst_n(rst_n),
      .op(cmd_op[p*OPW +: OPW]), .tag(cmd_tag[p*TW +: TW]),
      .rd(cmd_rd[p*AW +: AW]), .data(cmd_data[p*DW +: DW]),
      .va(va_w[p]), .vb(vb_w[p]),
      .wr_en(we_w[p]), .wr_addr(wa_w[p]), .wr_data(wd_w[p]),
      .rsp_vld(rsp_vld[p]), .rsp_code(rsp_code[p*2 +: 2]),
      .rsp_tag(rsp_tag[p*TW +: TW]), .rsp_data(rsp_data[p*DW +: DW])
    );

    for (genvar q = p + 1; q < NP; q++) begin : g_pair
      // R14: tags unique across ports within a cycle
      p_tag_unique_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op[p*OPW +: OPW] != OP_NOP && cmd_op[q*OPW +: OPW] != OP_NOP)
          |-> cmd_tag[p*TW +: TW] != cmd_tag[q*TW +: TW]);
    end
  end
endmodule

// File: tb/tb_calc_core.sv
`timescale 1ns/1ps
module tb_calc_core;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0]  cmd_op = '0;
  logic [7:0]   cmd_tag = '0;
  logic [15:0]  cmd_ra = '0, cmd_rb = '0, cmd_rd = '0;
  logic [127:0] cmd_data = '0;
  logic [3:0]   rsp_vld;
  logic [7:0]   rsp_code;
  logic [7:0]   rsp_tag;
  logic [127:0] rsp_data;

  always #2 clk = ~clk;

  calc_core dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_tag(cmd_tag),
    .cmd_ra(cmd_ra), .cmd_rb(cmd_rb), .cmd_rd(cmd_rd), .cmd_data(cmd_data),
    .rsp_vld(rsp_vld), .rsp_code(rsp_code), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  bit [31:0] m_reg [16];
  bit        m_skip [NP];
  int        b_op [NP], b_ra [NP], b_rb [NP], b_rd [NP];
  bit [31:0] b_data [NP];
  int        tbase = 0;
  string     req_override = "";

  task automatic clr();
    for (int p = 0; p < NP; p++) begin
      b_op[p] = 0; b_ra[p] = 0; b_rb[p] = 0; b_rd[p] = 0; b_data[p] = 0;
    end
  endtask

  task automatic set(int p, int op, int ra, int rb, int rd, bit [31:0] d);
    b_op[p] = op; b_ra[p] = ra; b_rb[p] = rb; b_rd[p] = rd; b_data[p] = d;
  endtask

  function automatic string req_of(int op, bit skipped);
    if (skipped) return (op == 12 || op == 13) ? "R9" : "R8";
    case (op)
      0: return "R12";
      1: return "R2";
      2: return "R3";
      5, 6: return "R4";
      9: return "R5";
      10: return "R6";
      12, 13: return "R7";
      default: return "R10";
    endcase
  endfunction

  // One cycle: drive the commands, predict, wait for the edge, compare.
  task automatic step();
    bit [31:0] nreg [16];
    bit        e_vld [NP];
    bit [1:0]  e_code [NP];
    bit [31:0] e_data [NP];
    bit [1:0]  e_tag [NP];
    bit        w_en [NP];
    bit [31:0] w_val [NP];
    string     rq [NP];
    nreg = m_reg;
    for (int p = 0; p < NP; p++) begin
      bit [31:0] a, b;
      longint unsigned s;
      a = m_reg[b_ra[p]]; b = m_reg[b_rb[p]];
      e_tag[p] = 2'((p + tbase) % 4);
      w_en[p] = 0; w_val[p] = 0;
      e_vld[p] = (b_op[p] != 0); e_code[p] = 2'b00; e_data[p] = 0;
      rq[p] = req_of(b_op[p], m_skip[p] && b_op[p] != 0);
      cmd_op[p*4 +: 4]    = 4'(b_op[p]);
      cmd_tag[p*2 +: 2]   = e_tag[p];
      cmd_ra[p*4 +: 4]    = 4'(b_ra[p]);
      cmd_rb[p*4 +: 4]    = 4'(b_rb[p]);
      cmd_rd[p*4 +: 4]    = 4'(b_rd[p]);
      cmd_data[p*32 +: 32] = b_data[p];
      if (b_op[p] == 0) begin
        // idle: nothing
      end else if (m_skip[p]) begin
        e_code[p] = 2'b11; m_skip[p] = 0;
      end else begin
        e_code[p] = 2'b01; m_skip[p] = 0;
        case (b_op[p])
          1: begin
            s = longint'(a) + longint'(b);
            if (s > 64'hFFFF_FFFF) e_code[p] = 2'b10;
            else begin e_data[p] = 32'(s); w_en[p] = 1; w_val[p] = 32'(s); end
          end
          2: if (b > a) e_code[p] = 2'b10;
             else begin e_data[p] = a - b; w_en[p] = 1; w_val[p] = a - b; end
          5: begin e_data[p] = a << (b % 32); w_en[p] = 1; w_val[p] = e_data[p]; end
          6: begin e_data[p] = a >> (b % 32); w_en[p] = 1; w_val[p] = e_data[p]; end
          9: begin w_en[p] = 1; w_val[p] = b_data[p]; end
          10: e_data[p] = a;
          12: begin e_data[p] = (a == 0) ? 1 : 0; m_skip[p] = (a == 0); end
          13: begin e_data[p] = (a == b) ? 1 : 0; m_skip[p] = (a == b); end
          default: e_code[p] = 2'b10;
        endcase
      end
    end
    for (int p = NP - 1; p >= 0; p--) if (w_en[p]) nreg[b_rd[p]] = w_val[p];
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      string r;
      bit bad;
      r = (req_override != "") ? req_override : rq[p];
      n_tests++;
      bad = (rsp_vld[p] !== e_vld[p]) || (rsp_code[p*2 +: 2] !== e_code[p]) ||
            (rsp_data[p*32 +: 32] !== e_data[p]) ||
            (e_vld[p] && rsp_tag[p*2 +: 2] !== e_tag[p]);
      if (bad) begin
        n_fail++;
        $display("FAIL %s port%0d: got vld=%0b code=%0b tag=%0d data=%h, expected vld=%0b code=%0b tag=%0d data=%h",
                 r, p, rsp_vld[p], rsp_code[p*2 +: 2], rsp_tag[p*2 +: 2], rsp_data[p*32 +: 32],
                 e_vld[p], e_code[p], e_tag[p], e_data[p]);
      end
    end
    m_reg = nreg;
    tbase++;
    clr();
  endtask

  function automatic bit [31:0] pick_val(int k);
    case (k % 5)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_reg[i] = 0;
    for (int p = 0; p < NP; p++) m_skip[p] = 0;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of responses
    for (int p = 0; p < NP; p++) begin
      n_tests++;
      if (rsp_vld[p] !== 1'b0 || rsp_code[p*2 +: 2] !== 2'b00) begin
        n_fail++;
        $display("FAIL R1 port%0d: got vld=%0b code=%0b, expected vld=0 code=0",
                 p, rsp_vld[p], rsp_code[p*2 +: 2]);
      end
    end
    // R1: every register reads zero after reset
    req_override = "R1";
    for (int g = 0; g < 4; g++) begin
      for (int p = 0; p < NP; p++) set(p, 10, g*4 + p, 0, 0, 0);
      step();
    end
    req_override = "";

    // R5: stores on all ports
    set(0, 9, 0, 0, 1, 32'd5); set(1, 9, 0, 0, 2, 32'd7);
    set(2, 9, 0, 0, 3, 32'hFFFF_FFFF); set(3, 9, 0, 0, 4, 32'd1);
    step();
    set(0, 9, 0, 0, 6, 32'd6); set(1, 9, 0, 0, 7, 32'hFFFF_FFFE);
    step();
    // R2: add normal, overflow by one, sum FFFFFFFF
    set(0, 1, 1, 2, 5, 0); set(1, 1, 3, 4, 8, 0);
    set(2, 1, 3, 0, 9, 0); set(3, 1, 7, 4, 10, 0);
    step();
    // R3: equal operands, underflow by one; R6 fetch of untouched overflow dest
    set(0, 2, 1, 1, 11, 0); set(1, 2, 1, 6, 12, 0);
    set(2, 2, 2, 1, 13, 0); set(3, 10, 8, 0, 0, 0);
    step();
    // R4: shifts by 0, 31
    set(0, 5, 1, 0, 14, 0); set(1, 6, 3, 0, 14, 0);
    step();
    set(2, 9, 0, 0, 15, 32'd31); step();
    set(0, 5, 4, 15, 14, 0); set(1, 6, 3, 15, 13, 0); step();
    // R10: illegal opcodes
    set(0, 3, 1, 2, 1, 0); set(1, 15, 1, 2, 2, 0); set(2, 4, 0, 0, 3, 0); step();
    set(0, 10, 1, 0, 0, 0); set(1, 10, 2, 0, 0, 0); set(2, 10, 3, 0, 0, 0); step();
    // R7/R8: taken branch on port 0, idle gap, store skipped; port 1 unaffected
    set(0, 12, 0, 0, 0, 0); set(1, 13, 1, 2, 0, 0); step();
    step();
    set(0, 9, 0, 0, 1, 32'hDEAD); set(1, 9, 0, 0, 2, 32'hBEEF); step();
    set(0, 10, 1, 0, 0, 0); set(1, 10, 2, 0, 0, 0); step();
    // R9: branch following taken branch is skipped, next store executes
    set(2, 13, 1, 1, 0, 0); step();
    set(2, 12, 0, 0, 0, 0); step();
    set(2, 9, 0, 0, 5, 32'h1234); step();
    set(2, 10, 5, 0, 0, 0); step();
    // R8: skipped fetch and skipped add
    set(3, 12, 0, 0, 0, 0); step();
    set(3, 10, 5, 0, 0, 0); step();
    set(3, 12, 0, 0, 0, 0); step();
    set(3, 1, 1, 1, 5, 0); step();
    set(3, 10, 5, 0, 0, 0); step();
    // R11: all ports write the same register
    req_override = "R11";
    set(0, 9, 0, 0, 9, 32'hA0); set(1, 9, 0, 0, 9, 32'hA1);
    set(2, 9, 0, 0, 9, 32'hA2); set(3, 1, 1, 2, 9, 0); step();
    set(1, 10, 9, 0, 0, 0); step();
    // R13: same-cycle read sees old value, next cycle sees new
    req_override = "R13";
    set(0, 9, 0, 0, 9, 32'h55); set(1, 10, 9, 0, 0, 0); step();
    set(1, 10, 9, 0, 0, 0); set(2, 1, 9, 9, 10, 0); step();
    set(3, 10, 10, 0, 0, 0); step();
    req_override = "";

    // random mix across all ports
    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < NP; p++) begin
        int k;
        k = $urandom_range(0, 11);
        case (k)
          0: set(p, 0, 0, 0, 0, 0);
          1: set(p, 1, $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15), 0);
          2: set(p, 2, $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15), 0);
          3: set(p, 5, $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15), 0);
          4: set(p, 6, $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15), 0);
          5, 6: set(p, 9, 0, 0, $urandom_range(0, 15), pick_val($urandom_range(0, 9)));
          7: set(p, 10, $urandom_range(0, 15), 0, 0, 0);
          8: set(p, 12, $urandom_range(0, 15), 0, 0, 0);
          9: set(p, 13, $urandom_range(0, 15), $urandom_range(0, 15), 0, 0);
          10: set(p, 7 + 4 * $urandom_range(0, 2), 0, 0, $urandom_range(0, 15), 0);
          default: set(p, 0, 0, 0, 0, 0);
        endcase
      end
      step();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule